// File: doc/BRIEF.md
# Audio InfoFrame Word Formatter

This block turns a set of audio stream settings into the register words that a display transmitter needs to send an audio InfoFrame. The settings are the channel count, the speaker allocation byte, the level-shift value, the down-mix inhibit flag, the sample-present mask and an enable bit. From these the block computes the InfoFrame checksum, packs two payload words, a layout/debug word and an audio packet control word. It also rewrites a control word that the caller supplies: only the four InfoFrame enable bits change, and every other bit is passed through.

The caller presents the settings and the current control word, then pulses `start` for one cycle. On the next clock edge all result words are registered, and `done` pulses for that cycle. The results stay unchanged until the next `start`. A channel count that cannot be represented is replaced by two channels, and an error flag is raised alongside the results.

Top module: `aif_formatter`

## Requirements
- R1: When enabled, the checksum byte in `word0_o[7:0]` makes the 8-bit sum of the header bytes 0x84, 0x01 and 0x0A, the channel code byte, the allocation byte, the byte {down_mix, level_shift, 3'b000} and the checksum itself equal to zero. The channel code is the effective channel count minus one.
- R2: When enabled, `word0_o` holds the checksum in bits [7:0] and the channel code in bits [10:8]. All other bits are zero.
- R3: When enabled, `word1_o` holds the allocation byte in bits [7:0], the level shift in bits [14:11] and the down-mix flag in bit 15. All other bits are zero.
- R4: `ctrl_o` equals the `ctrl_prev_i` sampled at `start`, except bits [7:4]. Those bits are 4'hF when enabled and 4'h0 when disabled.
- R5: When enabled with an effective channel count above 2, `dbg_o` has bit 4 set and the sample-present mask in bits [3:0]. For exactly 2 channels `dbg_o` is zero.
- R6: When disabled, `word0_o`, `word1_o`, `dbg_o` and `pkt_o` are all zero, whatever the other settings are.
- R7: When enabled, `pkt_o` has bit 0 set and the layout flag in bit 1; every other bit is zero. The layout flag is 0 for an effective count of exactly 2 channels and 1 otherwise.
- R8: The outputs take their new values on the clock edge that samples `start`, and `done` is high for exactly that one cycle. Without `start`, the outputs hold their values even if the inputs change.
- R9: When enabled, a channel count outside 2..8 is treated as 2 channels and `err_o` is set with the results. `err_o` is 0 for a count in range and whenever the block is disabled.
- R10: While reset is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to format the current inputs |
| enable_i | input | 1 | 1 = audio InfoFrame on, 0 = off |
| chans_i | input | 4 | Number of audio channels (valid 2..8) |
| alloc_i | input | 8 | Speaker allocation byte |
| lvl_shift_i | input | 4 | Level-shift value |
| dmix_i | input | 1 | Down-mix inhibit flag |
| smp_mask_i | input | 4 | Sample-present mask for multichannel layout |
| ctrl_prev_i | input | 32 | Current control word to be edited |
| word0_o | output | 32 | Payload word with checksum and channel code |
| word1_o | output | 32 | Payload word with allocation, level shift, down-mix |
| dbg_o | output | 32 | Layout and sample-present word |
| ctrl_o | output | 32 | Control word with the enable nibble rewritten |
| pkt_o | output | 32 | Audio packet control word |
| err_o | output | 1 | Channel count was out of range and was replaced by 2 |
| done | output | 1 | One-cycle pulse when results update |

## Verification
The bench sweeps every 4-bit channel count. A design that let 0, 1 or 9..15 through unclamped would put the wrong channel code into `word0_o` and a nonzero layout bit into `pkt_o`, and it would miss `err_o`. Control words of all ones and all zeros show whether the edit reaches bits outside [7:4], or leaves the nibble untouched when the block is disabled. Settings with the top bits set (down-mix 1, level shift 0xF, allocation 0xFF) make the checksum sum wrap; a design that left out the shift of the level-shift byte or the carry handling would then produce a checksum that does not cancel. After each result the inputs are scrambled without `start`: a design that lets its outputs follow the inputs, or that holds `done` high, is caught.

// File: rtl/aif_pkg.sv
package aif_pkg;

    localparam int WORD_W  = 32;
    localparam int CHAN_W  = 4;
    localparam int CODE_W  = 3;
    localparam int MIN_CH  = 2;
    localparam int MAX_CH  = 8;

    localparam logic [7:0] HDR_TYPE = 8'h84;
    localparam logic [7:0] HDR_VER  = 8'h01;
    localparam logic [7:0] HDR_LEN  = 8'h0A;

    // Field positions inside the packed words
    localparam int W0_CODE_LSB  = 8;
    localparam int W1_LVL_LSB   = 11;
    localparam int W1_DMIX_BIT  = 15;
    localparam int DBG_LAY_BIT  = 4;
    localparam int PKT_LAY_BIT  = 1;

    typedef struct packed {
        logic                enable;
        logic [CHAN_W-1:0]   chans;
        logic [7:0]          alloc;
        logic [3:0]          lvl;
        logic                dmix;
        logic [3:0]          smp;
    } aif_cfg_t;

    typedef struct packed {
        logic [CODE_W-1:0]   code;
        logic                layout;
        logic                err;
    } chan_info_t;

    typedef struct packed {
        logic [WORD_W-1:0]   w0;
        logic [WORD_W-1:0]   w1;
        logic [WORD_W-1:0]   dbg;
        logic [WORD_W-1:0]   ctrl;
        logic [WORD_W-1:0]   pkt;
        logic                err;
    } aif_words_t;

    // Level shift and down-mix as they appear in the frame byte
    function automatic logic [7:0] lvl_byte(input logic [3:0] lvl, input logic dmix);
        return {dmix, lvl, 3'b000};
    endfunction

endpackage

// File: rtl/aif_chan_decode.sv
module aif_chan_decode
    import aif_pkg::*;
(
    input  logic              enable,
    input  logic [CHAN_W-1:0] chans,
    output chan_info_t        info
);
    localparam logic [CHAN_W-1:0] LO = CHAN_W'(MIN_CH);
    localparam logic [CHAN_W-1:0] HI = CHAN_W'(MAX_CH);

    logic              in_range;
    logic [CHAN_W-1:0] eff;

    always_comb begin
        in_range    = (chans >= LO) && (chans <= HI);
        eff         = in_range ? chans : LO;
        info.code   = CODE_W'(eff - CHAN_W'(1));
        info.layout = (eff != LO);
        info.err    = enable & ~in_range;
    end
endmodule

// File: rtl/aif_checksum.sv
module aif_checksum
    import aif_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [7:0]        alloc,
    input  logic [3:0]        lvl,
    input  logic              dmix,
    output logic [7:0]        csum
);
    localparam logic [7:0] HDR_SUM = HDR_TYPE + HDR_VER + HDR_LEN;

    logic [7:0] acc;

    always_comb begin
        acc  = HDR_SUM + {{(8-CODE_W){1'b0}}, code} + alloc + lvl_byte(lvl, dmix);
        csum = 8'd0 - acc;
    end
endmodule

// File: rtl/aif_word_pack.sv
module aif_word_pack
    import aif_pkg::*;
#(
    parameter int EN_LSB   = 4,
    parameter int EN_WIDTH = 4
) (
    input  aif_cfg_t          cfg,
    input  chan_info_t        info,
    input  logic [7:0]        csum,
    input  logic [WORD_W-1:0] ctrl_prev,
    output aif_words_t        words
);
    logic [WORD_W-1:0] ctrl_next;

    // Rewrite only the enable field; pass every other bit
    for (genvar i = 0; i < WORD_W; i++) begin : g_ctrl
        if (i >= EN_LSB && i < EN_LSB + EN_WIDTH) begin : g_field
            assign ctrl_next[i] = cfg.enable;
        end else begin : g_keep
            assign ctrl_next[i] = ctrl_prev[i];
        end
    end

    always_comb begin
        words      = '0;
        words.ctrl = ctrl_next;
        words.err  = info.err;
        if (cfg.enable) begin
            words.w0[7:0]                          = csum;
            words.w0[W0_CODE_LSB +: CODE_W]        = info.code;
            words.w1[7:0]                          = cfg.alloc;
            words.w1[W1_LVL_LSB +: 4]              = cfg.lvl;
            words.w1[W1_DMIX_BIT]                  = cfg.dmix;
            words.pkt[0]                           = 1'b1;
            words.pkt[PKT_LAY_BIT]                 = info.layout;
            if (info.layout) begin
                words.dbg[DBG_LAY_BIT]             = 1'b1;
                words.dbg[3:0]                     = cfg.smp;
            end
        end
    end
endmodule

// File: rtl/aif_formatter.sv
module aif_formatter
    import aif_pkg::*;
#(
    parameter int EN_LSB   = 4,
    parameter int EN_WIDTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              enable_i,
    input  logic [3:0]        chans_i,
    input  logic [7:0]        alloc_i,
    input  logic [3:0]        lvl_shift_i,
    input  logic              dmix_i,
    input  logic [3:0]        smp_mask_i,
    input  logic [31:0]       ctrl_prev_i,
    output logic [31:0]       word0_o,
    output logic [31:0]       word1_o,
    output logic [31:0]       dbg_o,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       pkt_o,
    output logic              err_o,
    output logic              done
);
    aif_cfg_t   cfg;
    chan_info_t info;
    logic [7:0] csum;
    aif_words_t nxt;
    aif_words_t held;

    always_comb begin
        cfg.enable = enable_i;
        cfg.chans  = chans_i;
        cfg.alloc  = alloc_i;
        cfg.lvl    = lvl_shift_i;
        cfg.dmix   = dmix_i;
        cfg.smp    = smp_mask_i;
    end

    aif_chan_decode u_dec (
        .enable (cfg.enable),
        .chans  (cfg.chans),
        .info   (info)
    );

    aif_checksum u_sum (
        .code   (info.code),
        .alloc  (cfg.alloc),
        .lvl    (cfg.lvl),
        .dmix   (cfg.dmix),
        .csum   (csum)
    );

    aif_word_pack #(
        .EN_LSB   (EN_LSB),
        .EN_WIDTH (EN_WIDTH)
    ) u_pack (
        .cfg       (cfg),
        .info      (info),
        .csum      (csum),
        .ctrl_prev (ctrl_prev_i),
        .words     (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            done <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                held <= nxt;
            end
        end
    end

    assign word0_o = held.w0;
    assign word1_o = held.w1;
    assign dbg_o   = held.dbg;
    assign ctrl_o  = held.ctrl;
    assign pkt_o   = held.pkt;
    assign err_o   = held.err;
endmodule

// File: rtl/aif_formatter_chk.sv
module aif_formatter_chk #(
    parameter int EN_LSB   = 4,
    parameter int EN_WIDTH = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        enable_i,
    input logic [31:0] ctrl_prev_i,
    input logic [31:0] word0_o,
    input logic [31:0] word1_o,
    input logic [31:0] dbg_o,
    input logic [31:0] ctrl_o,
    input logic [31:0] pkt_o,
    input logic        err_o,
    input logic        done
);
    localparam logic [31:0] FIELD = ((32'h1 << EN_WIDTH) - 32'h1) << EN_LSB;

    logic [7:0] frame_sum;
    assign frame_sum = 8'h8F + {5'b0, word0_o[10:8]} + word0_o[7:0]
                     + word1_o[7:0] + {word1_o[15], word1_o[14:11], 3'b000};

    assert_done_after_start_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    assert_done_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start));
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(word0_o) && $stable(word1_o) && $stable(dbg_o)
                    && $stable(ctrl_o) && $stable(pkt_o) && $stable(err_o)));
    assert_ctrl_keep_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> ((ctrl_o & ~FIELD) == ($past(ctrl_prev_i) & ~FIELD)));
    assert_off_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(enable_i)) |-> (word0_o == 0 && word1_o == 0 && dbg_o == 0
                                        && pkt_o == 0 && !err_o));
    assert_checksum_R1: assert property (@(posedge clk) disable iff (rst)
        (done && $past(enable_i)) |-> (frame_sum == 8'h00));
    assert_stereo_dbg_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !pkt_o[1]) |-> (dbg_o == 32'h0));
    assert_err_clamp_R9: assert property (@(posedge clk) disable iff (rst)
        (done && err_o) |-> (pkt_o == 32'h1 && word0_o[10:8] == 3'd1));
endmodule

bind aif_formatter aif_formatter_chk #(
    .EN_LSB   (EN_LSB),
    .EN_WIDTH (EN_WIDTH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .enable_i    (enable_i),
    .ctrl_prev_i (ctrl_prev_i),
    .word0_o     (word0_o),
    .word1_o     (word1_o),
    .dbg_o       (dbg_o),
    .ctrl_o      (ctrl_o),
    .pkt_o       (pkt_o),
    .err_o       (err_o),
    .done        (done)
);

// File: tb/sim_aif_formatter.sv
`timescale 1ns/1ps
module sim_aif_formatter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        enable_i = 1'b0;
    logic [3:0]  chans_i = '0;
    logic [7:0]  alloc_i = '0;
    logic [3:0]  lvl_shift_i = '0;
    logic        dmix_i = 1'b0;
    logic [3:0]  smp_mask_i = '0;
    logic [31:0] ctrl_prev_i = '0;
    logic [31:0] word0_o, word1_o, dbg_o, ctrl_o, pkt_o;
    logic        err_o, done;

    always #2.5 clk = ~clk;

    aif_formatter u0 (
        .clk(clk), .rst(rst), .start(start), .enable_i(enable_i),
        .chans_i(chans_i), .alloc_i(alloc_i), .lvl_shift_i(lvl_shift_i),
        .dmix_i(dmix_i), .smp_mask_i(smp_mask_i), .ctrl_prev_i(ctrl_prev_i),
        .word0_o(word0_o), .word1_o(word1_o), .dbg_o(dbg_o), .ctrl_o(ctrl_o),
        .pkt_o(pkt_o), .err_o(err_o), .done(done)
    );

    typedef struct {
        bit          en;
        logic [31:0] w0, w1, dbg, ctrl, pkt;
        logic        err;
    } exp_t;

    exp_t q[$];
    exp_t last;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input bit en, input int ch, input int al,
                                   input int lv, input int dm, input int sm,
                                   input logic [31:0] prev);
        exp_t e;
        bit ok;
        int eff, code, sum, cs;
        bit lay;
        ok   = (ch >= 2) && (ch <= 8);
        eff  = ok ? ch : 2;
        code = eff - 1;
        lay  = (eff != 2);
        e.en = en;
        e.w0 = 0; e.w1 = 0; e.dbg = 0; e.pkt = 0; e.err = 0;
        if (en) begin
            sum  = (132 + 1 + 10 + code + al + lv * 8 + dm * 128) % 256;
            cs   = (256 - sum) % 256;
            e.w0 = 32'(cs + code * 256);
            e.w1 = 32'(al + lv * 2048 + dm * 32768);
            e.dbg = lay ? 32'(16 + sm) : 32'h0;
            e.pkt = lay ? 32'h3 : 32'h1;
            e.err = !ok;
            e.ctrl = (prev & ~32'hF0) | 32'hF0;
        end else begin
            e.ctrl = prev & ~32'hF0;
        end
        return e;
    endfunction

    // Monitor: pop and compare at each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_t e;
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected done actual=1 expected=0");
            end else begin
                string tag;
                e = q.pop_front();
                tag = e.en ? "R2" : "R6";
                chk(tag, "word0", word0_o, e.w0);
                chk(e.en ? "R3" : "R6", "word1", word1_o, e.w1);
                chk(e.en ? "R5" : "R6", "dbg", dbg_o, e.dbg);
                chk("R4", "ctrl", ctrl_o, e.ctrl);
                chk(e.en ? "R7" : "R6", "pkt", pkt_o, e.pkt);
                chk("R9", "err", {31'b0, err_o}, {31'b0, e.err});
            end
        end
    end

    // Driver: one request, then an idle cycle with scrambled inputs
    task automatic run(input bit en, input int ch, input int al, input int lv,
                       input int dm, input int sm, input logic [31:0] prev);
        @(negedge clk);
        enable_i    = en;
        chans_i     = 4'(ch);
        alloc_i     = 8'(al);
        lvl_shift_i = 4'(lv);
        dmix_i      = 1'(dm);
        smp_mask_i  = 4'(sm);
        ctrl_prev_i = prev;
        last = model(en, ch, al, lv, dm, sm, prev);
        q.push_back(last);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        enable_i    = ~en;
        chans_i     = ~chans_i;
        alloc_i     = ~alloc_i;
        lvl_shift_i = ~lvl_shift_i;
        dmix_i      = ~dmix_i;
        smp_mask_i  = ~smp_mask_i;
        ctrl_prev_i = ~prev;
        @(negedge clk);
        // R8: no new pulse and outputs held without start
        chk("R8", "done low", {31'b0, done}, 32'h0);
        chk("R8", "hold word0", word0_o, last.w0);
        chk("R8", "hold ctrl", ctrl_o, last.ctrl);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "word0", word0_o, 0);
        chk("R10", "word1", word1_o, 0);
        chk("R10", "dbg", dbg_o, 0);
        chk("R10", "ctrl", ctrl_o, 0);
        chk("R10", "pkt", pkt_o, 0);
        chk("R10", "err/done", {30'b0, err_o, done}, 0);
        rst = 1'b0;

        // R1 R2 R3: stereo defaults and a wrapping checksum
        run(1, 2, 8'h00, 0, 0, 4'h0, 32'h0000_0000);
        run(1, 8, 8'h13, 5, 1, 4'hF, 32'h1234_5678);
        run(1, 8, 8'hFF, 15, 1, 4'hA, 32'hFFFF_FFFF);
        // R5: multichannel layout with sample-present mask
        run(1, 3, 8'h01, 2, 0, 4'h3, 32'hA5A5_A50F);
        run(1, 6, 8'h0B, 9, 0, 4'h7, 32'h0000_0000);
        // R6 R4: disabled clears payload and the enable nibble
        run(0, 8, 8'hFF, 15, 1, 4'hF, 32'hFFFF_FFFF);
        run(0, 0, 8'h44, 3, 1, 4'h1, 32'h0000_00F0);
        // R9: every channel count, including 0, 1 and 9..15
        for (int c = 0; c < 16; c++) begin
            run(1, c, (c * 37) % 256, c % 16, c % 2, (c * 5) % 16, 32'(c * 32'h0101_0101));
        end

        repeat (3) @(negedge clk);
        chk("R8", "queue drained", 32'(q.size()), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule